// File: doc/BRIEF.md
# VLAN Table Command Engine

This block keeps a small table of VLAN entries and changes it on behalf of a host that sees only a handful of 16-bit registers. The host fills in a VID register, per-port data registers and a database number, then writes an operation code into the operation register with its busy bit set. The engine then does one of four things: it loads or removes one entry, it invalidates the whole table, it searches for the next valid VID, or it hands over a recorded VLAN violation. When it is finished it clears busy by itself.

The table is indexed directly by VID and holds `TBL_DEPTH` entries. Each entry stores a valid flag, a database number masked to `NUM_DB` values, and four bits per port. In each nibble the low two bits are the member tag and the upper two bits are the port state. The search walks the table one entry per clock. It writes the VID it finds back into the VID register, so repeating the operation without touching that register continues the walk.

A packet-side source reports violations with a source port, a VID and a type (member or miss). The first report is held and drives an interrupt until the host fetches it. Further reports are dropped while one is held.

Top module: `vlan_cmd_engine`

## Requirements
- R1: Writing the operation register (address 0) stores the written value. If bit 15 (busy) is set, an operation starts and bit 15 reads 1 until the operation ends, then clears by itself. With bit 15 clear, no operation starts. The operation code is bits 14:12.
- R2: While busy is 1, every host write to any register is ignored.
- R3: Code 4 (get-next) finds the lowest valid VID strictly above the VID register value and writes it back. VID register (address 1): bits 11:0 are VID[11:0], bit 12 is valid, bit 13 is VID[12]. The write-back sets the valid bit and loads the entry's data into the data registers and its database number into the operation register. A repeated get-next continues from that VID.
- R4: When get-next finds no higher valid VID, it clears the valid bit and leaves the other VID register bits unchanged.
- R5: A get-next that starts from s = VID+1 and finds entry k keeps busy for k-s+1 cycles. When it finds nothing it keeps busy for TBL_DEPTH-s+1 cycles, with a minimum of 1. Every other operation keeps busy for 1 cycle.
- R6: Code 3 (load/purge) with the VID valid bit set writes the entry for that VID from the data registers and the database number. A VID of TBL_DEPTH or more leaves the table unchanged.
- R7: Code 3 with the VID valid bit clear removes the entry for that VID.
- R8: Code 1 invalidates every table entry.
- R9: The database number is taken from operation bits 3:0 (low nibble) and 11:8 (high nibble), and is masked to NUM_DB values. Get-next returns it in the same split fields.
- R10: Data register at address 2+r holds ports 4r to 4r+3. Port p occupies bits 4(p mod 4)+3 to 4(p mod 4): member tag in the low two bits, state in the upper two. The register values round-trip through a load followed by a get-next.
- R11: A violation report while none is held is captured, and irq is 1 from the next cycle. Reports that arrive while one is held are dropped.
- R12: Code 7 (fetch violation) writes the source port into operation bits 3:0. It sets bit 6 for a member violation or bit 5 for a miss violation. It writes the VID into VID register bits 11:0 and 13, clears the held violation, and drops irq. With nothing held, bits 6, 5 and 3:0 become 0 and the VID register is unchanged.
- R13: Codes 0, 2, 5 and 6 change nothing except clearing busy after one cycle.
- R14: Reset clears all table entries, all registers and any held violation, and drives irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Register address: 0 operation, 1 VID, 2.. data |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr, combinational |
| viol_valid | input | 1 | Violation report strobe |
| viol_port | input | 4 | Source port of the violation |
| viol_vid | input | 13 | VID of the violation |
| viol_miss | input | 1 | 1 = miss violation, 0 = member violation |
| irq | output | 1 | High while a violation is held |

## Verification
Get-next is driven against three table shapes:
- Two entries with a gap and one VID above the table. This separates the stop-on-first-hit behaviour from a scan that skips entries, and shows that an out-of-range load has no effect.
- The same table after a purge and after a flush. This separates removing one entry from clearing all of them.
- An empty table after reset.

The busy duration of each search is compared with the distance walked. This distinguishes a one-entry-per-clock walk from an early or late stop.

Violation reports are sent as a held member report, a dropped second report, a fetch with nothing held, and a miss report. Together these tell the two flag bits, the drop rule and the clear apart.

// File: rtl/vlan_cmd_pkg.sv
package vlan_cmd_pkg;

  localparam int unsigned REG_W         = 16;
  localparam int unsigned ADDR_OP       = 0;
  localparam int unsigned ADDR_VID      = 1;
  localparam int unsigned ADDR_DAT0     = 2;

  localparam int unsigned BUSY_B        = 15;
  localparam int unsigned VID_VALID_B   = 12;
  localparam int unsigned VID_PAGE_B    = 13;
  localparam int unsigned VIOL_MEMBER_B = 6;
  localparam int unsigned VIOL_MISS_B   = 5;

  typedef enum logic [2:0] {
    OPC_FLUSH = 3'd1,
    OPC_LOAD  = 3'd3,
    OPC_NEXT  = 3'd4,
    OPC_VIOL  = 3'd7
  } opc_e;

endpackage

// File: rtl/vlan_rst_sync.sv
module vlan_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_sn  <= stage_q;
    end
  end
endmodule

// File: rtl/vlan_tbl_store.sv
module vlan_tbl_store #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int FID_W = 6,
  parameter int DW    = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wvalid,
  input  logic [FID_W-1:0] wfid,
  input  logic [DW-1:0]    wdat,
  input  logic [IDX_W-1:0] ridx,
  output logic             rvalid,
  output logic [FID_W-1:0] rfid,
  output logic [DW-1:0]    rdat
);
  logic [DEPTH-1:0]       v_q, v_d;
  logic [DEPTH*FID_W-1:0] f_q, f_d;
  logic [DEPTH*DW-1:0]    d_q, d_d;

  // per-entry next state: one write port, flush overrides
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit;
    assign hit = we && (widx == IDX_W'(e));
    assign v_d[e] = flush ? 1'b0 : (hit ? wvalid : v_q[e]);
    assign f_d[e*FID_W +: FID_W] = (hit && wvalid) ? wfid : f_q[e*FID_W +: FID_W];
    assign d_d[e*DW +: DW]       = (hit && wvalid) ? wdat : d_q[e*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      f_q <= '0;
      d_q <= '0;
    end else begin
      v_q <= v_d;
      f_q <= f_d;
      d_q <= d_d;
    end
  end

  assign rvalid = v_q[ridx];
  assign rfid   = f_q[int'(ridx)*FID_W +: FID_W];
  assign rdat   = d_q[int'(ridx)*DW +: DW];
endmodule

// File: rtl/vlan_viol_latch.sv
module vlan_viol_latch #(
  parameter int PORT_W = 4,
  parameter int VID_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_port,
  input  logic [VID_W-1:0]  in_vid,
  input  logic              in_miss,
  input  logic              clr,
  output logic              pend,
  output logic [PORT_W-1:0] port,
  output logic [VID_W-1:0]  vid,
  output logic              miss
);
  logic              pend_d, miss_d, cap;
  logic [PORT_W-1:0] port_d;
  logic [VID_W-1:0]  vid_d;

  assign cap = in_valid && !pend;

  always_comb begin
    pend_d = pend;
    port_d = port;
    vid_d  = vid;
    miss_d = miss;
    if (cap) begin
      pend_d = 1'b1;
      port_d = in_port;
      vid_d  = in_vid;
      miss_d = in_miss;
    end else if (clr) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      port <= '0;
      vid  <= '0;
      miss <= 1'b0;
    end else begin
      pend <= pend_d;
      port <= port_d;
      vid  <= vid_d;
      miss <= miss_d;
    end
  end
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vlan_cmd_pkg::*;
#(
  parameter int NUM_PORTS = 12,
  parameter int TBL_DEPTH = 16,
  parameter int NUM_DB    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        viol_valid,
  input  logic [3:0]  viol_port,
  input  logic [12:0] viol_vid,
  input  logic        viol_miss,
  output logic        irq
);
  localparam int NUM_DREG = (NUM_PORTS + 3) / 4;
  localparam int DW       = NUM_DREG * REG_W;
  localparam int IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
  localparam int FID_W    = (NUM_DB > 1) ? $clog2(NUM_DB) : 1;
  localparam logic [13:0] DEPTH_V = 14'(TBL_DEPTH);

  function automatic logic [DW-1:0] port_mask();
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < NUM_PORTS * 4);
    return m;
  endfunction
  localparam logic [DW-1:0] DAT_MASK = port_mask();

  logic              rst_sn;
  logic [15:0]       op_q, op_d;
  logic [13:0]       vid_q, vid_d;
  logic [DW-1:0]     dat_q, dat_d;
  logic [13:0]       scan_q, scan_d;
  logic              busy, done, in_range;
  logic [2:0]        opc;
  logic [12:0]       vid13;
  logic              tbl_we, tbl_flush, tbl_rvalid;
  logic [FID_W-1:0]  ld_fid, tbl_rfid;
  logic [DW-1:0]     tbl_rdat;
  logic [7:0]        fid_ext;
  logic              viol_clr, pend, pend_miss;
  logic [3:0]        pend_port;
  logic [12:0]       pend_vid;

  vlan_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_sn (rst_sn)
  );

  assign busy     = op_q[BUSY_B];
  assign opc      = op_q[14:12];
  assign vid13    = {vid_q[VID_PAGE_B], vid_q[11:0]};
  assign in_range = ({1'b0, vid13} < DEPTH_V);
  assign ld_fid   = FID_W'({op_q[11:8], op_q[3:0]});
  assign fid_ext  = 8'(tbl_rfid);

  vlan_tbl_store #(
    .DEPTH (TBL_DEPTH),
    .IDX_W (IDX_W),
    .FID_W (FID_W),
    .DW    (DW)
  ) u_tbl (
    .clk    (clk),
    .rst_n  (rst_sn),
    .flush  (tbl_flush),
    .we     (tbl_we),
    .widx   (vid13[IDX_W-1:0]),
    .wvalid (vid_q[VID_VALID_B]),
    .wfid   (ld_fid),
    .wdat   (dat_q),
    .ridx   (scan_q[IDX_W-1:0]),
    .rvalid (tbl_rvalid),
    .rfid   (tbl_rfid),
    .rdat   (tbl_rdat)
  );

  vlan_viol_latch #(
    .PORT_W (4),
    .VID_W  (13)
  ) u_viol (
    .clk      (clk),
    .rst_n    (rst_sn),
    .in_valid (viol_valid),
    .in_port  (viol_port),
    .in_vid   (viol_vid),
    .in_miss  (viol_miss),
    .clr      (viol_clr),
    .pend     (pend),
    .port     (pend_port),
    .vid      (pend_vid),
    .miss     (pend_miss)
  );

  assign irq = pend;

  // next-state: host register writes when idle, one step of the running operation when busy
  always_comb begin
    op_d      = op_q;
    vid_d     = vid_q;
    dat_d     = dat_q;
    scan_d    = scan_q;
    tbl_we    = 1'b0;
    tbl_flush = 1'b0;
    viol_clr  = 1'b0;
    done      = 1'b0;
    if (busy) begin
      done = 1'b1;
      case (opc)
        OPC_FLUSH: tbl_flush = 1'b1;
        OPC_LOAD:  tbl_we    = in_range;
        OPC_NEXT: begin
          if (scan_q >= DEPTH_V) begin
            vid_d[VID_VALID_B] = 1'b0;
          end else if (tbl_rvalid) begin
            vid_d      = {scan_q[12], 1'b1, scan_q[11:0]};
            op_d[11:8] = fid_ext[7:4];
            op_d[3:0]  = fid_ext[3:0];
            dat_d      = tbl_rdat;
          end else begin
            done   = 1'b0;
            scan_d = scan_q + 14'd1;
          end
        end
        OPC_VIOL: begin
          viol_clr            = 1'b1;
          op_d[3:0]           = pend ? pend_port : 4'd0;
          op_d[VIOL_MEMBER_B] = pend && !pend_miss;
          op_d[VIOL_MISS_B]   = pend && pend_miss;
          if (pend) begin
            vid_d[11:0]       = pend_vid[11:0];
            vid_d[VID_PAGE_B] = pend_vid[12];
          end
        end
        default: ;
      endcase
      if (done) op_d[BUSY_B] = 1'b0;
    end else if (host_wr) begin
      if (host_addr == 3'(ADDR_OP)) begin
        op_d   = host_wdata;
        scan_d = {1'b0, vid13} + 14'd1;
      end else if (host_addr == 3'(ADDR_VID)) begin
        vid_d = host_wdata[13:0];
      end
      for (int r = 0; r < NUM_DREG; r++) begin
        if (host_addr == 3'(ADDR_DAT0 + r))
          dat_d[r*REG_W +: REG_W] = host_wdata & DAT_MASK[r*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      op_q   <= '0;
      vid_q  <= '0;
      dat_q  <= '0;
      scan_q <= '0;
    end else begin
      op_q   <= op_d;
      vid_q  <= vid_d;
      dat_q  <= dat_d;
      scan_q <= scan_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == 3'(ADDR_OP))  host_rdata = op_q;
    if (host_addr == 3'(ADDR_VID)) host_rdata = {2'b00, vid_q};
    for (int r = 0; r < NUM_DREG; r++) begin
      if (host_addr == 3'(ADDR_DAT0 + r)) host_rdata = dat_q[r*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/vlan_cmd_chk.sv
module vlan_cmd_chk
  import vlan_cmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [2:0]  host_addr,
  input logic        start_bit,
  input logic        busy,
  input logic [2:0]  opc,
  input logic [15:0] op_q,
  input logic [13:0] vid_q,
  input logic        irq
);
  // R1: an accepted start raises busy on the next cycle
  a_r1_busy_sets: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !busy && host_addr == 3'(ADDR_OP) && start_bit |=> busy);

  // R5: every operation other than get-next takes one cycle
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy && opc != OPC_NEXT |=> !busy);

  // R2: during a search, neither register moves until it completes
  a_r2_hold_during_scan: assert property (@(posedge clk) disable iff (!rst_n)
    busy && opc == OPC_NEXT |=> (!busy || ($stable(op_q) && $stable(vid_q))));

  // R3: a successful search returns a VID strictly above the start value
  a_r3_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(busy) && $past(opc) == OPC_NEXT && vid_q[VID_VALID_B]
    |-> {vid_q[VID_PAGE_B], vid_q[11:0]} > {$past(vid_q[VID_PAGE_B]), $past(vid_q[11:0])});

  // R11: a held violation stays held until a fetch runs
  a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !busy |=> irq);

  // R12: a fetch that finds a held violation drops irq
  a_r12_fetch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq && busy && opc == OPC_VIOL |=> !irq);
endmodule

bind vlan_cmd_engine vlan_cmd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .start_bit (host_wdata[15]),
  .busy      (busy),
  .opc       (opc),
  .op_q      (op_q),
  .vid_q     (vid_q),
  .irq       (irq)
);

// File: tb/sim_vlan_cmd_engine.sv
module sim_vlan_cmd_engine;
  localparam int NP = 12, DEPTH = 16, NDB = 64, ND = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        viol_valid = 1'b0;
  logic [3:0]  viol_port = '0;
  logic [12:0] viol_vid = '0;
  logic        viol_miss = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  vlan_cmd_engine #(.NUM_PORTS(NP), .TBL_DEPTH(DEPTH), .NUM_DB(NDB)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .viol_valid(viol_valid),
    .viol_port(viol_port), .viol_vid(viol_vid), .viol_miss(viol_miss), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done_flag = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_op, m_vid, m_cnt, m_hit, m_pport, m_pvid;
  int m_dat[ND];
  bit m_tv[DEPTH];
  int m_tf[DEPTH];
  int m_td[DEPTH][ND];
  bit m_pend, m_pmiss;

  function automatic int m_vid13();
    return (m_vid & 'hFFF) | (((m_vid >> 13) & 1) << 12);
  endfunction

  function automatic int m_read(int a);
    if (a == 0) return m_op;
    if (a == 1) return m_vid;
    if (a >= 2 && a < 2 + ND) return m_dat[a-2];
    return 0;
  endfunction

  task automatic m_reset();
    m_op = 0; m_vid = 0; m_cnt = 0; m_hit = -1; m_pend = 0; m_pport = 0; m_pvid = 0; m_pmiss = 0;
    for (int r = 0; r < ND; r++) m_dat[r] = 0;
    for (int k = 0; k < DEPTH; k++) begin
      m_tv[k] = 0; m_tf[k] = 0;
      for (int r = 0; r < ND; r++) m_td[k][r] = 0;
    end
  endtask

  task automatic m_finish();
    int code, idx, f;
    code = (m_op >> 12) & 7;
    m_op = m_op & ~'h8000;
    case (code)
      1: for (int k = 0; k < DEPTH; k++) m_tv[k] = 0;
      3: begin
        idx = m_vid13();
        if (idx < DEPTH) begin
          if ((m_vid >> 12) & 1) begin
            m_tv[idx] = 1;
            m_tf[idx] = ((((m_op >> 8) & 'hF) << 4) | (m_op & 'hF)) & (NDB - 1);
            for (int r = 0; r < ND; r++) m_td[idx][r] = m_dat[r];
          end else m_tv[idx] = 0;
        end
      end
      4: begin
        if (m_hit >= 0) begin
          f = m_tf[m_hit];
          m_vid = (m_vid & ~'h3FFF) | 'h1000 | (m_hit & 'hFFF) | (((m_hit >> 12) & 1) << 13);
          m_op = (m_op & ~'h0F0F) | (f & 'hF) | (((f >> 4) & 'hF) << 8);
          for (int r = 0; r < ND; r++) m_dat[r] = m_td[m_hit][r];
        end else m_vid = m_vid & ~'h1000;
      end
      7: begin
        m_op = m_op & ~'h006F;
        if (m_pend) begin
          m_op = m_op | m_pport | (m_pmiss ? 'h20 : 'h40);
          m_vid = (m_vid & 'h1000) | (m_pvid & 'hFFF) | (((m_pvid >> 12) & 1) << 13);
          m_pend = 0;
        end
      end
      default: ;
    endcase
  endtask

  task automatic m_step();
    bit cap;
    int s;
    if (!rst_n) begin
      m_reset();
      return;
    end
    cap = viol_valid && !m_pend;
    if ((m_op >> 15) & 1) begin
      m_cnt--;
      if (m_cnt == 0) m_finish();
    end else if (host_wr) begin
      if (host_addr == 0) begin
        m_op = host_wdata;
        if (host_wdata[15]) begin
          m_cnt = 1;
          if (((host_wdata >> 12) & 7) == 4) begin
            s = m_vid13() + 1;
            m_hit = -1;
            for (int k = s; k < DEPTH; k++) if (m_tv[k] && m_hit < 0) m_hit = k;
            if (m_hit >= 0) m_cnt = m_hit - s + 1;
            else m_cnt = (s >= DEPTH) ? 1 : DEPTH - s + 1;
          end
        end
      end else if (host_addr == 1) m_vid = host_wdata & 'h3FFF;
      else if (host_addr >= 2 && host_addr < 2 + ND) m_dat[host_addr-2] = host_wdata;
    end
    if (cap) begin
      m_pend = 1; m_pport = viol_port; m_pvid = viol_vid; m_pmiss = viol_miss;
    end
  endtask

  // compared on every clock, after the edge has settled
  always @(posedge clk) begin
    m_step();
    #2;
    if (!done_flag) begin
      if (host_addr == 0) check("R1 per-cycle operation register", host_rdata, m_read(host_addr));
      else if (host_addr == 1) check("R3 per-cycle VID register", host_rdata, m_read(host_addr));
      else check("R10 per-cycle data register", host_rdata, m_read(host_addr));
      check("R11 per-cycle irq", irq, m_pend);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    host_wr = 1; host_addr = 3'(a); host_wdata = 16'(d);
    @(negedge clk);
    host_wr = 0; host_addr = 0;
  endtask

  task automatic op_go(int d, output int lat);
    @(negedge clk);
    host_wr = 1; host_addr = 0; host_wdata = 16'(d);
    @(negedge clk);
    host_wr = 0;
    #1;
    lat = 0;
    while (host_rdata[15] && lat < 5000) begin
      lat++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    host_addr = 3'(a);
    #1;
    v = host_rdata;
  endtask

  task automatic viol(int p, int v, bit miss);
    @(negedge clk);
    viol_valid = 1; viol_port = 4'(p); viol_vid = 13'(v); viol_miss = miss;
    @(negedge clk);
    viol_valid = 0;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, lat;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R14 reset state
    rd(0, v); check("R14 op after reset", v, 0);
    rd(1, v); check("R14 vid after reset", v, 0);
    rd(3, v); check("R14 data after reset", v, 0);
    check("R14 irq after reset", irq, 0);

    // R6 load VID 5 (fid 0x23) and VID 9 (fid 0xFF, masked), VID 20 out of range
    wr(2, 'h1111); wr(3, 'h2222); wr(4, 'h3333); wr(1, 'h1005);
    op_go('hB203, lat); check("R5 load latency", lat, 1);
    wr(2, 'hA5A5); wr(3, 'h0F0F); wr(4, 'hC3C3); wr(1, 'h1009);
    op_go('hBF0F, lat);
    wr(1, 'h1014);
    op_go('hB000, lat); check("R6 out-of-range load latency", lat, 1);

    // R3 get-next from 0 finds 5
    wr(1, 'h0000);
    op_go('hC000, lat); check("R5 get-next latency to 5", lat, 5);
    rd(1, v); check("R3 vid after first get-next", v, 'h1005);
    rd(0, v); check("R9 split fid of VID 5", v, 'h4203);
    rd(2, v); check("R10 data reg 0 round trip", v, 'h1111);
    rd(3, v); check("R10 data reg 1 round trip", v, 'h2222);
    rd(4, v); check("R10 data reg 2 round trip", v, 'h3333);
    // continue without rewriting the VID register
    op_go('hC000, lat); check("R5 get-next latency to 9", lat, 4);
    rd(1, v); check("R3 continued scan finds 9", v, 'h1009);
    rd(0, v); check("R9 fid masked to 0x3F", v, 'h430F);
    rd(3, v); check("R10 data reg 1 of VID 9", v, 'h0F0F);
    // R4 no further entry (VID 20 was not stored)
    op_go('hC000, lat); check("R5 miss latency", lat, 7);
    rd(1, v); check("R4 valid cleared, vid kept", v, 'h0009);

    // R7 purge VID 5
    wr(1, 'h0005);
    op_go('hB000, lat);
    wr(1, 'h0000);
    op_go('hC000, lat); check("R7 purged 5 skipped latency", lat, 9);
    rd(1, v); check("R7 next after purge is 9", v, 'h1009);

    // R2 writes ignored while busy
    wr(1, 'h0000);
    @(negedge clk); host_wr = 1; host_addr = 0; host_wdata = 'hC000;
    @(negedge clk); host_addr = 1; host_wdata = 'h0FFF;
    @(negedge clk); host_addr = 2; host_wdata = 'hFFFF;
    @(negedge clk); host_addr = 0; host_wdata = 'h9000;
    @(negedge clk); host_wr = 0;
    repeat (10) @(negedge clk);
    rd(1, v); check("R2 vid write ignored while busy", v, 'h1009);
    rd(2, v); check("R2 data write ignored while busy", v, 'hA5A5);
    rd(0, v); check("R2 op write ignored while busy", (v >> 12) & 7, 4);

    // R13 unknown code
    op_go('hA000, lat); check("R13 unknown code latency", lat, 1);
    rd(0, v); check("R13 op after unknown code", v, 'h2000);
    rd(1, v); check("R13 vid unchanged", v, 'h1009);
    // R1 no busy bit
    op_go('h4000, lat); check("R1 no start without busy bit", lat, 0);
    rd(0, v); check("R1 value stored", v, 'h4000);

    // R11 / R12 violations
    viol(7, 'h1234, 0);
    check("R11 irq after report", irq, 1);
    viol(3, 'h0010, 1);
    op_go('hF000, lat);
    rd(0, v); check("R12 member violation fields", v, 'h7047);
    rd(1, v); check("R12 violation vid", v, 'h3234);
    check("R12 irq cleared", irq, 0);
    op_go('hF000, lat);
    rd(0, v); check("R12 fetch with none held", v, 'h7000);
    rd(1, v); check("R11 dropped report not kept", v, 'h3234);
    viol(2, 'h0033, 1);
    op_go('hF000, lat);
    rd(0, v); check("R12 miss violation fields", v, 'h7022);
    rd(1, v); check("R12 miss violation vid", v, 'h1033);

    // R8 flush
    op_go('h9000, lat); check("R8 flush latency", lat, 1);
    wr(1, 'h0000);
    op_go('hC000, lat); check("R8 empty scan latency", lat, 16);
    rd(1, v); check("R8 nothing after flush", v, 'h0000);

    // R14 reset mid-run
    wr(1, 'h1003);
    op_go('hB000, lat);
    viol(1, 'h0005, 0);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R14 irq cleared by reset", irq, 0);
    rd(1, v); check("R14 vid cleared by reset", v, 0);
    op_go('hC000, lat); check("R14 table cleared by reset", lat, 16);
    rd(1, v); check("R14 no entry after reset", v, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule